// File: doc/BRIEF.md
# NAND Block Write-Protect Unit

This unit sits between the host-facing register file of a NAND flash controller and its flash sequencer, and decides whether each program or erase request may reach its target block. Software describes up to four protected-free regions as inclusive block ranges. Each region has its own enable flag, which a protection command turns on or off. A one-way freeze command makes the region setup permanent until the next reset. Reads always pass.

The unit also holds a single buffer-unlock flag. That flag gates host writes into the controller's internal page buffer. Requests are judged in one cycle. A permitted request appears on the forward port one clock later with its kind and block unchanged. A refused request produces a one-cycle deny pulse and sets a failure flag that stays set until reset.

Top module: `nand_wp_unit`

## Requirements
- R1: After reset every window is disabled, so every program and erase is refused. The buffer is write-locked, and the failure flag, the freeze flag, the forward valid and the deny pulse are all 0.
- R2: Register select 2*w writes the first block of window w and select 2*w+1 writes its last block, for w in 0..3. Select 8 is the protection command and select 9 is the configuration register.
- R3: A program (kind 1) or an erase (kind 2) is permitted only when its block lies within an enabled window, with both range ends inclusive.
- R4: A read (kind 0) is always forwarded, whatever the window state.
- R5: A refused request is not forwarded. It produces a one-cycle deny pulse and sets the failure flag, which stays 1 through later permitted requests until reset.
- R6: In a command word, bit 2 enables windows, bit 1 disables windows and bit 0 freezes the setup. Bits 11:8 select the windows affected, and a value of 0 selects all four. When several action bits are set, freeze outranks disable and disable outranks enable.
- R7: Once frozen, window register writes and enable/disable commands have no effect until reset, and the freeze flag reads 1.
- R8: Configuration bit 1 unlocks the buffer. The buffer write grant equals the host write request ANDed with that flag, combinationally. The configuration register stays writable while frozen.
- R9: Every request yields exactly one result one cycle later. A forwarded request carries the same kind and block as the request.
- R10: A window whose first block is greater than its last block matches no block.
- R11: A command write with any bit set outside bits 2:0 and 11:8 is ignored. A configuration write with any bit other than bit 1 set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select (R2) |
| reg_wdata | input | 16 | Register write data |
| op_valid | input | 1 | Operation request valid |
| op_kind | input | 2 | 0 read, 1 program, 2 erase, 3 treated like a modifying operation |
| op_block | input | 16 | Target block address |
| host_buf_wr | input | 1 | Host request to write the page buffer |
| buf_wr_grant | output | 1 | Buffer write allowed |
| fwd_valid | output | 1 | Permitted request passed to the sequencer |
| fwd_kind | output | 2 | Kind of the forwarded request |
| fwd_block | output | 16 | Block of the forwarded request |
| op_denied | output | 1 | One-cycle pulse for a refused request |
| fail_sticky | output | 1 | Set by any refusal, cleared by reset |
| tight_locked | output | 1 | Window setup frozen |

## Verification
The bench probes each window at its exact first and last block and one block beyond each end. An off-by-one range comparison would therefore refuse an edge block or admit a neighbour. It issues combined command words and masked commands, which expose wrong action priority or a mask that leaks into other windows. After the freeze it rewrites windows and sends enable and disable commands, then checks that the old ranges still govern. A design that let those writes through would start permitting blocks it should refuse, or refusing blocks it should permit. It also checks inverted windows, commands and configuration words with reserved bits set, and that the failure flag survives later permitted requests.

// File: rtl/nand_wp_pkg.sv
package nand_wp_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_ERASE   = 2'd2,
        OP_OTHER   = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_ENABLE = 2'd1,
        ACT_DISABLE = 2'd2,
        ACT_FREEZE = 2'd3
    } prot_act_e;

    localparam int CMD_FREEZE_BIT  = 0;
    localparam int CMD_DISABLE_BIT = 1;
    localparam int CMD_ENABLE_BIT  = 2;
    localparam int CMD_MASK_LSB    = 8;
    localparam int CFG_BUF_BIT     = 1;

    // Highest-priority action wins: freeze, then disable, then enable.
    function automatic prot_act_e pick_action(input logic [2:0] bits);
        if (bits[CMD_FREEZE_BIT])       return ACT_FREEZE;
        else if (bits[CMD_DISABLE_BIT]) return ACT_DISABLE;
        else if (bits[CMD_ENABLE_BIT])  return ACT_ENABLE;
        else                            return ACT_NONE;
    endfunction

    function automatic logic needs_permit(input op_kind_e kind);
        return kind != OP_READ;
    endfunction

endpackage

// File: rtl/nand_wp_window_bank.sv
module nand_wp_window_bank
    import nand_wp_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int BLK_W   = 16,
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_WIN-1:0] en_set,
    input  logic [NUM_WIN-1:0] en_clr,
    input  logic [BLK_W-1:0]   query_blk,
    output logic [NUM_WIN-1:0] hit
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [BLK_W-1:0] first_q;
        logic [BLK_W-1:0] last_q;
        logic             on_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                first_q <= '0;
                last_q  <= '0;
                on_q    <= 1'b0;
            end else begin
                if (wr_en && wr_sel == SEL_W'(2 * w))
                    first_q <= wr_data[BLK_W-1:0];
                if (wr_en && wr_sel == SEL_W'(2 * w + 1))
                    last_q <= wr_data[BLK_W-1:0];
                if (en_clr[w])
                    on_q <= 1'b0;
                else if (en_set[w])
                    on_q <= 1'b1;
            end
        end

        assign hit[w] = on_q && (query_blk >= first_q) && (query_blk <= last_q);
    end

endmodule

// File: rtl/nand_wp_cmd_ctrl.sv
module nand_wp_cmd_ctrl
    import nand_wp_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               host_req,
    output logic               win_wr_en,
    output logic [NUM_WIN-1:0] en_set,
    output logic [NUM_WIN-1:0] en_clr,
    output logic               frozen,
    output logic               buf_grant
);

    localparam int SEL_CMD = 2 * NUM_WIN;
    localparam int SEL_CFG = SEL_CMD + 1;
    localparam logic [DATA_W-1:0] CMD_LEGAL =
        DATA_W'(7) | (DATA_W'((1 << NUM_WIN) - 1) << CMD_MASK_LSB);
    localparam logic [DATA_W-1:0] CFG_LEGAL = DATA_W'(1) << CFG_BUF_BIT;

    logic               frozen_q;
    logic               buf_open_q;
    logic               cmd_wr;
    logic               cfg_wr;
    prot_act_e          act;
    logic [NUM_WIN-1:0] raw_mask;
    logic [NUM_WIN-1:0] eff_mask;

    assign cmd_wr = wr_en && (wr_sel == SEL_W'(SEL_CMD))
                    && ((wr_data & ~CMD_LEGAL) == '0);
    assign cfg_wr = wr_en && (wr_sel == SEL_W'(SEL_CFG))
                    && ((wr_data & ~CFG_LEGAL) == '0);

    assign act      = pick_action(wr_data[2:0]);
    assign raw_mask = wr_data[CMD_MASK_LSB +: NUM_WIN];
    assign eff_mask = (raw_mask == '0) ? '1 : raw_mask;

    always_comb begin
        en_set = '0;
        en_clr = '0;
        if (cmd_wr && !frozen_q) begin
            if (act == ACT_ENABLE)  en_set = eff_mask;
            if (act == ACT_DISABLE) en_clr = eff_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen_q   <= 1'b0;
            buf_open_q <= 1'b0;
        end else begin
            if (cmd_wr && act == ACT_FREEZE)
                frozen_q <= 1'b1;
            if (cfg_wr)
                buf_open_q <= wr_data[CFG_BUF_BIT];
        end
    end

    assign win_wr_en = wr_en && !frozen_q;
    assign frozen    = frozen_q;
    assign buf_grant = host_req && buf_open_q;

endmodule

// File: rtl/nand_wp_op_gate.sv
module nand_wp_op_gate
    import nand_wp_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int BLK_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  op_kind_e           req_kind,
    input  logic [BLK_W-1:0]   req_blk,
    input  logic [NUM_WIN-1:0] hit,
    output logic               out_valid,
    output op_kind_e           out_kind,
    output logic [BLK_W-1:0]   out_blk,
    output logic               deny_pulse,
    output logic               fail_flag
);

    logic allowed;

    assign allowed = !needs_permit(req_kind) || (|hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_kind   <= OP_READ;
            out_blk    <= '0;
            deny_pulse <= 1'b0;
            fail_flag  <= 1'b0;
        end else begin
            out_valid  <= req_valid && allowed;
            out_kind   <= req_kind;
            out_blk    <= req_blk;
            deny_pulse <= req_valid && !allowed;
            if (req_valid && !allowed)
                fail_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/nand_wp_unit.sv
module nand_wp_unit
    import nand_wp_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int BLK_W   = 16,
    parameter int DATA_W  = 16,
    parameter int SEL_W   = $clog2(2 * NUM_WIN + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [BLK_W-1:0]  op_block,
    input  logic              host_buf_wr,
    output logic              buf_wr_grant,
    output logic              fwd_valid,
    output logic [1:0]        fwd_kind,
    output logic [BLK_W-1:0]  fwd_block,
    output logic              op_denied,
    output logic              fail_sticky,
    output logic              tight_locked
);

    logic               win_wr_en;
    logic [NUM_WIN-1:0] en_set;
    logic [NUM_WIN-1:0] en_clr;
    logic [NUM_WIN-1:0] hit;
    op_kind_e           kind_in;
    op_kind_e           kind_out;

    assign kind_in  = op_kind_e'(op_kind);
    assign fwd_kind = kind_out;

    nand_wp_cmd_ctrl #(
        .NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_en(reg_we), .wr_sel(reg_sel), .wr_data(reg_wdata),
        .host_req(host_buf_wr),
        .win_wr_en(win_wr_en), .en_set(en_set), .en_clr(en_clr),
        .frozen(tight_locked), .buf_grant(buf_wr_grant)
    );

    nand_wp_window_bank #(
        .NUM_WIN(NUM_WIN), .BLK_W(BLK_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(win_wr_en), .wr_sel(reg_sel), .wr_data(reg_wdata),
        .en_set(en_set), .en_clr(en_clr),
        .query_blk(op_block), .hit(hit)
    );

    nand_wp_op_gate #(
        .NUM_WIN(NUM_WIN), .BLK_W(BLK_W)
    ) u_gate (
        .clk(clk), .rst(rst),
        .req_valid(op_valid), .req_kind(kind_in), .req_blk(op_block),
        .hit(hit),
        .out_valid(fwd_valid), .out_kind(kind_out), .out_blk(fwd_block),
        .deny_pulse(op_denied), .fail_flag(fail_sticky)
    );

endmodule

// File: rtl/nand_wp_unit_chk.sv
module nand_wp_unit_chk #(
    parameter int BLK_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [1:0]       op_kind,
    input logic [BLK_W-1:0] op_block,
    input logic             host_buf_wr,
    input logic             buf_wr_grant,
    input logic             fwd_valid,
    input logic [BLK_W-1:0] fwd_block,
    input logic             op_denied,
    input logic             fail_sticky,
    input logic             tight_locked
);

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fwd_valid && !op_denied && !fail_sticky && !tight_locked));

    a_r4_read_passes: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd0) |=> fwd_valid);

    a_r5_fail_holds: assert property (@(posedge clk) disable iff (rst)
        fail_sticky |=> fail_sticky);

    a_r5_deny_sets_fail: assert property (@(posedge clk) disable iff (rst)
        op_denied |-> fail_sticky);

    a_r5_not_both: assert property (@(posedge clk) disable iff (rst)
        !(fwd_valid && op_denied));

    a_r7_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        tight_locked |=> tight_locked);

    a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
        buf_wr_grant |-> host_buf_wr);

    a_r9_one_result: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (fwd_valid ^ op_denied));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!fwd_valid && !op_denied));

    a_r9_block_kept: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (fwd_block == $past(op_block)));

endmodule

bind nand_wp_unit nand_wp_unit_chk #(.BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst(rst),
    .op_valid(op_valid), .op_kind(op_kind), .op_block(op_block),
    .host_buf_wr(host_buf_wr), .buf_wr_grant(buf_wr_grant),
    .fwd_valid(fwd_valid), .fwd_block(fwd_block),
    .op_denied(op_denied), .fail_sticky(fail_sticky),
    .tight_locked(tight_locked)
);

// File: tb/test_nand_wp_unit.sv
module test_nand_wp_unit;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [15:0] op_block = '0;
    logic        host_buf_wr = 1'b0;
    logic        buf_wr_grant, fwd_valid, op_denied, fail_sticky, tight_locked;
    logic [1:0]  fwd_kind;
    logic [15:0] fwd_block;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        bit          permit;
        logic [1:0]  kind;
        logic [15:0] blk;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #HALF clk = ~clk;

    nand_wp_unit i_nand_wp_unit (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .op_valid(op_valid), .op_kind(op_kind),
        .op_block(op_block), .host_buf_wr(host_buf_wr),
        .buf_wr_grant(buf_wr_grant), .fwd_valid(fwd_valid),
        .fwd_kind(fwd_kind), .fwd_block(fwd_block), .op_denied(op_denied),
        .fail_sticky(fail_sticky), .tight_locked(tight_locked)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [3:0] sel, logic [15:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic op(logic [1:0] kind, logic [15:0] blk, bit permit, string tag);
        exp_t e;
        @(negedge clk);
        e.permit = permit; e.kind = kind; e.blk = blk; e.tag = tag;
        exp_q.push_back(e);
        op_valid = 1'b1; op_kind = kind; op_block = blk;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic grant_chk(bit req, bit expv, string tag);
        @(negedge clk);
        host_buf_wr = req;
        #1;
        chk(tag, 32'(buf_wr_grant), 32'(expv));
        host_buf_wr = 1'b0;
    endtask

    // Monitor: pops one expected item per request, one cycle after it.
    initial begin
        forever begin
            bit seen;
            exp_t e;
            @(posedge clk);
            seen = op_valid && !rst;
            #(HALF / 2);
            if (seen) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R9: result with no expected item");
                end else begin
                    e = exp_q.pop_front();
                    chk({e.tag, " fwd"}, 32'(fwd_valid), 32'(e.permit));
                    chk({e.tag, " deny"}, 32'(op_denied), 32'(!e.permit));
                    if (e.permit) begin
                        chk({e.tag, " R9 kind"}, 32'(fwd_kind), 32'(e.kind));
                        chk({e.tag, " R9 block"}, 32'(fwd_block), 32'(e.blk));
                    end
                end
            end
        end
    end

    initial begin
        #(2 * HALF * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        #1;
        chk("R1 fail", 32'(fail_sticky), 0);
        chk("R1 tight", 32'(tight_locked), 0);
        chk("R1 fwd", 32'(fwd_valid), 0);
        grant_chk(1, 0, "R1 buffer locked");
        op(2'd1, 16'h0005, 0, "R1 program refused");
        op(2'd2, 16'h0000, 0, "R1 erase refused");
        op(2'd0, 16'h0005, 1, "R4 read passes");
        op(2'd3, 16'h0005, 0, "R3 kind3 refused");
        #1 chk("R5 fail set", 32'(fail_sticky), 1);

        // R2/R3: window 1 range edges
        do_reset();
        wr(4'd2, 16'h0100);
        wr(4'd3, 16'h01FF);
        wr(4'd8, 16'h0204);            // R6 enable window 1
        op(2'd1, 16'h0100, 1, "R3 first edge");
        op(2'd2, 16'h01FF, 1, "R3 last edge");
        op(2'd1, 16'h00FF, 0, "R3 below");
        op(2'd1, 16'h0200, 0, "R3 above");
        op(2'd1, 16'h0150, 1, "R5 later permit");
        #1 chk("R5 fail stays", 32'(fail_sticky), 1);

        // R6: full-range window 0, mask 0 means all
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'hFFFF);
        wr(4'd8, 16'h0004);
        op(2'd1, 16'hABCD, 1, "R6 all enabled");
        op(2'd2, 16'hFFFF, 1, "R6 top block");
        wr(4'd8, 16'h0102);            // disable window 0 only
        op(2'd1, 16'h0050, 0, "R6 masked disable");
        op(2'd1, 16'h0150, 1, "R6 other window kept");
        wr(4'd8, 16'h0006);            // disable+enable: disable wins
        op(2'd1, 16'h0150, 0, "R6 priority");

        // R10: inverted window
        wr(4'd4, 16'h0300);
        wr(4'd5, 16'h02FF);
        wr(4'd8, 16'h0404);
        op(2'd1, 16'h0300, 0, "R10 first");
        op(2'd1, 16'h02FF, 0, "R10 last");

        // R11: reserved bits void a command
        wr(4'd8, 16'h1004);
        op(2'd1, 16'h0150, 0, "R11 reserved cmd ignored");

        // R7: freeze
        do_reset();
        #1 chk("R7 cleared by reset", 32'(tight_locked), 0);
        wr(4'd6, 16'h0010);
        wr(4'd7, 16'h0020);
        wr(4'd8, 16'h0804);
        wr(4'd8, 16'h0001);
        #1 chk("R7 tight", 32'(tight_locked), 1);
        wr(4'd6, 16'h0000);
        op(2'd1, 16'h0005, 0, "R7 window write ignored");
        op(2'd1, 16'h0010, 1, "R7 old range kept");
        wr(4'd8, 16'h0002);
        op(2'd2, 16'h0015, 1, "R7 disable ignored");
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'hFFFF);
        wr(4'd8, 16'h0004);
        op(2'd1, 16'h0100, 0, "R7 enable ignored");
        wr(4'd9, 16'h0002);
        grant_chk(1, 1, "R8 config writable when frozen");

        // R8/R11: buffer lock
        do_reset();
        grant_chk(1, 0, "R8 locked after reset");
        wr(4'd9, 16'h0003);
        grant_chk(1, 0, "R11 reserved cfg ignored");
        wr(4'd9, 16'h0002);
        grant_chk(1, 1, "R8 unlocked");
        grant_chk(0, 0, "R8 no request");
        wr(4'd9, 16'h0000);
        grant_chk(1, 0, "R8 relocked");

        repeat (3) @(negedge clk);
        chk("R9 queue drained", 32'(exp_q.size()), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule